// File: doc/BRIEF.md
# Host Register Bus Slave with Falling-Edge Handshake

This block connects a 32-bit host processor bus to a small internal register file. The host marks a cycle with an active-low select, gives its direction with an active-low write strobe, and marks valid write data with an active-low data strobe. Two active-low half-word selects choose the upper and lower 16-bit lanes. The block samples every input on the falling edge of the host bus clock. When a cycle qualifies, the block answers with an active-low acknowledge. On a read it also drives the data bus. Data and acknowledge each come with a separate output-enable instead of a true tri-state net, and the pad ring builds the high-impedance drivers from that pair.

The handshake is a three-state machine clocked on the falling edge. In state S_IDLE the acknowledge is released. The transition T_QUALIFY leads to S_ACK when select is low, at least one word select is low, and the cycle is a read or a write with the data strobe low. The register access happens on that same edge. In S_ACK the acknowledge is driven low. The transition T_END leads to S_REL once select is sampled high. In S_REL the acknowledge is driven high for one clock. The transition T_DONE then returns the machine to S_IDLE, where the acknowledge driver is switched off. A two-bit mute input can turn off acknowledge driving for reads, for writes, or for both.

The word address selects one of four regions and a word within it. The general and insertion regions accept only full 32-bit writes. The maintenance region accepts half-word writes. The fourth region is unmapped. An active-low DMA request shows that the insertion buffer may be written. A full write to its last word clears the request, and an internal consume pulse sets it again.

Top module: `hostbus_slave`

## Requirements
- R1: After reset, ack_oe and data_oe are 0, ack_n is 1, dma_req_n is 0, and every register reads as 0.
- R2: A cycle qualifies on a falling edge that samples sel_n=0, at least one of hiw_n and low_n at 0, and either wr_n=1 or dstb_n=0. Until that edge, ack_oe stays 0. After that edge, ack_n=0 and ack_oe=1, unless the acknowledge is muted.
- R3: The acknowledge ends one falling edge after sel_n is sampled high. For one clock it shows ack_n=1 with ack_oe=1 (ack_oe=0 when muted). On the next falling edge ack_oe returns to 0.
- R4: data_oe is 1 only during an acknowledged read while sel_n=0 and wr_n=1. During that time rdata_out holds the addressed word as it stood when the cycle qualified.
- R5: Address bits [3:2] select the region: 0 general, 1 insertion, 2 maintenance, 3 unmapped. Bits [1:0] select one of four words. Bits [23:4] are ignored. The unmapped region reads as 0 and ignores writes.
- R6: A write to the general or insertion region with only one word select low leaves the register unchanged, but the cycle is still acknowledged.
- R7: In the maintenance region, hiw_n=0 writes bits [31:16] and low_n=0 writes bits [15:0]. Each lane is written independently.
- R8: ack_mute[0]=1 suppresses acknowledge driving (ack_oe stays 0) for reads, and ack_mute[1]=1 does the same for writes. The value is sampled when the cycle qualifies.
- R9: A full 32-bit write to insertion word 3 sets dma_req_n to 1 on the qualifying edge.
- R10: A consume pulse sampled on a falling edge sets dma_req_n to 0. If a last-word insertion write qualifies on the same edge, the write wins and dma_req_n becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host bus clock; all logic acts on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Cycle select, active low |
| dstb_n | input | 1 | Write data valid strobe, active low |
| wr_n | input | 1 | Direction: 0 write, 1 read |
| hiw_n | input | 1 | Upper half-word select, active low |
| low_n | input | 1 | Lower half-word select, active low |
| addr | input | 24 | Word address (host address bits 25..2) |
| wdata_in | input | 32 | Write data from the host |
| ack_mute | input | 2 | Bit 0 mutes read acknowledge, bit 1 mutes write acknowledge |
| consume | input | 1 | Internal pulse: insertion buffer emptied |
| rdata_out | output | 32 | Read data for the data bus driver |
| data_oe | output | 1 | Enable for the data bus driver |
| ack_n | output | 1 | Acknowledge level, active low |
| ack_oe | output | 1 | Enable for the acknowledge driver |
| dma_req_n | output | 1 | Insertion buffer free, active low |

## Verification
The hardest case to reach from the ports is a consume pulse and a last-word insertion write landing on the same falling edge, because the two update paths of the request flag then collide. The bench raises consume in the same cycle as a directed full write to insertion word 3 and checks that the request stays deasserted. The other hard cases are cycles that must not qualify: a write with the data strobe still high, and a select with neither word select low. These are held open for several edges and then completed, to show that the acknowledge waits for them. Random cycles mix every region, lane combination, mute setting and address alias against a bench-side model of the register file.

// File: rtl/hbs_pkg.sv
package hbs_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_ACK  = 2'd1,
        S_REL  = 2'd2
    } hbs_state_t;

    typedef enum logic [1:0] {
        RG_GEN  = 2'd0,
        RG_INS  = 2'd1,
        RG_MNT  = 2'd2,
        RG_NONE = 2'd3
    } hbs_region_t;
endpackage

// File: rtl/hbs_fsm.sv
module hbs_fsm
    import hbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_n,
    input  logic       dstb_n,
    input  logic       wr_n,
    input  logic       hiw_n,
    input  logic       low_n,
    input  logic [1:0] ack_mute,
    output logic       acc_go,
    output logic       acc_rd,
    output logic       ack_n,
    output logic       ack_oe,
    output logic       data_oe
);
    hbs_state_t state;
    logic       rd_q;
    logic       quiet_q;
    logic       qual;
    logic       mute_now;

    assign qual     = !sel_n && (!hiw_n || !low_n) && (wr_n || !dstb_n);
    assign mute_now = wr_n ? ack_mute[0] : ack_mute[1];
    assign acc_go   = (state == S_IDLE) && qual;
    assign acc_rd   = wr_n;

    // state register, falling edge
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            rd_q    <= 1'b0;
            quiet_q <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (qual) begin            // T_QUALIFY
                    state   <= S_ACK;
                    rd_q    <= wr_n;
                    quiet_q <= mute_now;
                end
                S_ACK:  if (sel_n) state <= S_REL; // T_END
                S_REL:  state <= S_IDLE;           // T_DONE
                default: state <= S_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        ack_n   = 1'b1;
        ack_oe  = 1'b0;
        data_oe = 1'b0;
        unique case (state)
            S_IDLE: begin
                ack_n  = 1'b1;
                ack_oe = 1'b0;
            end
            S_ACK: begin
                ack_n   = quiet_q;
                ack_oe  = !quiet_q;
                data_oe = rd_q && !sel_n && wr_n;
            end
            S_REL: begin
                ack_n  = 1'b1;
                ack_oe = !quiet_q;
            end
            default: begin
                ack_n  = 1'b1;
                ack_oe = 1'b0;
            end
        endcase
    end

    assert_ack_after_qual_R2: assert property (@(negedge clk) disable iff (!rst_n)
        (state == S_IDLE && qual && !mute_now) |=> (ack_oe && !ack_n));

    assert_no_ack_unqualified_R2: assert property (@(negedge clk) disable iff (!rst_n)
        (state == S_IDLE && !qual) |=> !ack_oe);

    assert_release_high_R3: assert property (@(negedge clk) disable iff (!rst_n)
        $fell(ack_oe) |-> $past(ack_n));

    assert_end_after_sel_R3: assert property (@(negedge clk) disable iff (!rst_n)
        (state == S_ACK && !sel_n) |=> (state == S_ACK));
endmodule

// File: rtl/hbs_regs.sv
module hbs_regs
    import hbs_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              hiw_n,
    input  logic              low_n,
    input  logic              consume,
    output logic [DATA_W-1:0] rdata,
    output logic              dma_req_n
);
    localparam int WORDS  = 1 << IDX_W;
    localparam int HALF   = DATA_W / 2;
    localparam int NREG   = 4;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(WORDS - 1);

    hbs_region_t       region;
    logic [IDX_W-1:0]  idx;
    logic              full;
    logic              wr_go;
    logic              last_wr;
    logic [DATA_W-1:0] rword [NREG];

    assign region  = hbs_region_t'(addr[IDX_W+1:IDX_W]);
    assign idx     = addr[IDX_W-1:0];
    assign full    = !hiw_n && !low_n;
    assign wr_go   = go && !rd;
    assign last_wr = wr_go && region == RG_INS && idx == LAST && full;

    for (genvar g = 0; g < NREG; g++) begin : g_region
        if (g == int'(RG_NONE)) begin : g_unmapped
            assign rword[g] = '0;
        end else begin : g_mapped
            logic [DATA_W-1:0] cells [WORDS];
            logic              sel_here;
            logic              hi_en;
            logic              lo_en;
            assign sel_here = wr_go && (region == hbs_region_t'(g));
            if (g == int'(RG_MNT)) begin : g_lanes
                assign hi_en = !hiw_n;
                assign lo_en = !low_n;
            end else begin : g_fullonly
                assign hi_en = full;
                assign lo_en = full;
            end
            always_ff @(negedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int w = 0; w < WORDS; w++) cells[w] <= '0;
                end else if (sel_here) begin
                    if (hi_en) cells[idx][DATA_W-1:HALF] <= wdata[DATA_W-1:HALF];
                    if (lo_en) cells[idx][HALF-1:0]      <= wdata[HALF-1:0];
                end
            end
            assign rword[g] = cells[idx];
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (go && rd) begin
            rdata <= rword[region];
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n)        dma_req_n <= 1'b0;
        else if (last_wr)  dma_req_n <= 1'b1;
        else if (consume)  dma_req_n <= 1'b0;
    end

    assert_dma_clear_R9: assert property (@(negedge clk) disable iff (!rst_n)
        $rose(dma_req_n) |-> $past(wr_go && region == RG_INS));

    assert_dma_set_R10: assert property (@(negedge clk) disable iff (!rst_n)
        $fell(dma_req_n) |-> $past(consume));

    assert_unmapped_zero_R5: assert property (@(negedge clk) disable iff (!rst_n)
        (go && rd && region == RG_NONE) |=> (rdata == '0));
endmodule

// File: rtl/hostbus_slave.sv
module hostbus_slave #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              dstb_n,
    input  logic              wr_n,
    input  logic              hiw_n,
    input  logic              low_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic [1:0]        ack_mute,
    input  logic              consume,
    output logic [DATA_W-1:0] rdata_out,
    output logic              data_oe,
    output logic              ack_n,
    output logic              ack_oe,
    output logic              dma_req_n
);
    logic acc_go;
    logic acc_rd;

    hbs_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_n    (sel_n),
        .dstb_n   (dstb_n),
        .wr_n     (wr_n),
        .hiw_n    (hiw_n),
        .low_n    (low_n),
        .ack_mute (ack_mute),
        .acc_go   (acc_go),
        .acc_rd   (acc_rd),
        .ack_n    (ack_n),
        .ack_oe   (ack_oe),
        .data_oe  (data_oe)
    );

    hbs_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (acc_go),
        .rd        (acc_rd),
        .addr      (addr),
        .wdata     (wdata_in),
        .hiw_n     (hiw_n),
        .low_n     (low_n),
        .consume   (consume),
        .rdata     (rdata_out),
        .dma_req_n (dma_req_n)
    );
endmodule

// File: tb/hostbus_slave_test.sv
`timescale 1ns/1ps
module hostbus_slave_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n = 1'b1, dstb_n = 1'b1, wr_n = 1'b1, hiw_n = 1'b1, low_n = 1'b1;
    logic [23:0] addr = '0;
    logic [31:0] wdata_in = '0;
    logic [1:0]  ack_mute = '0;
    logic        consume = 1'b0;
    logic [31:0] rdata_out;
    logic        data_oe, ack_n, ack_oe, dma_req_n;

    int checks = 0;
    int errors = 0;
    logic [31:0] m [16];
    logic        mdma;

    always #10 clk = ~clk;

    hostbus_slave uut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .dstb_n(dstb_n), .wr_n(wr_n),
        .hiw_n(hiw_n), .low_n(low_n), .addr(addr), .wdata_in(wdata_in),
        .ack_mute(ack_mute), .consume(consume), .rdata_out(rdata_out),
        .data_oe(data_oe), .ack_n(ack_n), .ack_oe(ack_oe), .dma_req_n(dma_req_n)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [23:0] a);
        return (a[3:2] == 2'd3) ? 32'h0 : m[a[3:0]];
    endfunction

    function automatic void model_write(input logic [23:0] a, input logic [31:0] d,
                                        input bit hi, input bit lo, input bit cons);
        logic [1:0] g;
        g = a[3:2];
        if (g < 2'd2 && hi && lo) m[a[3:0]] = d;
        if (g == 2'd2) begin
            if (hi) m[a[3:0]][31:16] = d[31:16];
            if (lo) m[a[3:0]][15:0]  = d[15:0];
        end
        if (g == 2'd1 && a[1:0] == 2'd3 && hi && lo) mdma = 1'b1;
        else if (cons) mdma = 1'b0;
    endfunction

    task automatic idle_bus();
        sel_n = 1'b1; dstb_n = 1'b1; wr_n = 1'b1; hiw_n = 1'b1; low_n = 1'b1; consume = 1'b0;
    endtask

    task automatic xfer(input bit rd, input logic [23:0] a, input logic [31:0] d,
                        input bit hi, input bit lo, input logic [1:0] mute, input bit cons);
        bit q;
        logic [31:0] ev;
        q  = rd ? mute[0] : mute[1];
        ev = exp_read(a);
        @(posedge clk); #1;
        sel_n = 1'b0; wr_n = rd; dstb_n = rd; hiw_n = !hi; low_n = !lo;
        addr = a; wdata_in = d; ack_mute = mute; consume = cons;
        @(negedge clk); #5;
        if (!rd) model_write(a, d, hi, lo, cons);
        else if (cons) mdma = 1'b0;
        if (q) chk(ack_oe == 1'b0, "R8 muted ack_oe", {31'd0, ack_oe}, 32'd0);
        else   chk(ack_oe == 1'b1 && ack_n == 1'b0, "R2 ack asserted", {30'd0, ack_oe, ack_n}, 32'd2);
        if (rd) chk(data_oe == 1'b1 && rdata_out == ev, "R4/R5 read data", rdata_out, ev);
        else    chk(data_oe == 1'b0, "R4 no drive on write", {31'd0, data_oe}, 32'd0);
        chk(dma_req_n == mdma, "R9/R10 dma request", {31'd0, dma_req_n}, {31'd0, mdma});
        @(posedge clk); #1;
        idle_bus();
        #2;
        chk(data_oe == 1'b0, "R4 data released with select", {31'd0, data_oe}, 32'd0);
        @(negedge clk); #5;
        if (q) chk(ack_oe == 1'b0, "R8 muted release", {31'd0, ack_oe}, 32'd0);
        else   chk(ack_oe == 1'b1 && ack_n == 1'b1, "R3 driven high", {30'd0, ack_oe, ack_n}, 32'd3);
        @(negedge clk); #5;
        chk(ack_oe == 1'b0, "R3 released", {31'd0, ack_oe}, 32'd0);
    endtask

    task automatic pulse_consume();
        @(posedge clk); #1; consume = 1'b1;
        @(negedge clk); #5; mdma = 1'b0;
        chk(dma_req_n == 1'b0, "R10 consume sets request", {31'd0, dma_req_n}, 32'd0);
        @(posedge clk); #1; consume = 1'b0;
    endtask

    initial begin
        #(20.0 * 150000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h5eed);
        for (int i = 0; i < 16; i++) m[i] = '0;
        mdma = 1'b0;
        #35; rst_n = 1'b1;
        #5;
        chk(ack_oe == 1'b0 && data_oe == 1'b0 && ack_n == 1'b1, "R1 reset outputs",
            {29'd0, ack_oe, data_oe, ack_n}, 32'd1);
        chk(dma_req_n == 1'b0, "R1 reset dma", {31'd0, dma_req_n}, 32'd0);
        for (int i = 0; i < 16; i++) xfer(1, 24'(i), 0, 1, 1, 2'b00, 0); // R1 zeros

        // R5 general write and alias read
        xfer(0, 24'h000001, 32'hCAFE_0001, 1, 1, 2'b00, 0);
        xfer(1, 24'hABC001, 0, 1, 1, 2'b00, 0);
        // R6 partial writes ignored
        xfer(0, 24'h000001, 32'h1111_2222, 1, 0, 2'b00, 0);
        xfer(0, 24'h000005, 32'h3333_4444, 0, 1, 2'b00, 0);
        xfer(1, 24'h000001, 0, 1, 1, 2'b00, 0);
        xfer(1, 24'h000005, 0, 1, 1, 2'b00, 0);
        // R7 maintenance lanes
        xfer(0, 24'h000009, 32'hAAAA_BBBB, 1, 0, 2'b00, 0);
        xfer(0, 24'h000009, 32'hCCCC_DDDD, 0, 1, 2'b00, 0);
        xfer(1, 24'h000009, 0, 0, 1, 2'b00, 0);
        // R5 unmapped region
        xfer(0, 24'h00000E, 32'hFFFF_FFFF, 1, 1, 2'b00, 0);
        xfer(1, 24'h00000E, 0, 1, 1, 2'b00, 0);
        // R8 mutes
        xfer(1, 24'h000001, 0, 1, 1, 2'b01, 0);
        xfer(0, 24'h000002, 32'h0BAD_F00D, 1, 1, 2'b10, 0);
        xfer(0, 24'h000003, 32'h0000_0077, 1, 1, 2'b01, 0);
        xfer(1, 24'h000002, 0, 1, 1, 2'b10, 0);
        // R9 last insertion word clears request, R10 consume sets it
        xfer(0, 24'h000006, 32'h1, 1, 1, 2'b00, 0);
        xfer(0, 24'h000007, 32'h2, 1, 1, 2'b00, 0);
        chk(dma_req_n == 1'b1, "R9 request cleared", {31'd0, dma_req_n}, 32'd1);
        pulse_consume();
        xfer(0, 24'h000007, 32'h3, 0, 1, 2'b00, 0);
        chk(dma_req_n == 1'b0, "R9 partial write keeps request", {31'd0, dma_req_n}, 32'd0);
        // R10 collision: write wins
        xfer(0, 24'h000007, 32'h4, 1, 1, 2'b00, 1);
        chk(dma_req_n == 1'b1, "R10 write wins over consume", {31'd0, dma_req_n}, 32'd1);
        pulse_consume();

        // R2 write held without data strobe, then strobed
        @(posedge clk); #1;
        sel_n = 1'b0; wr_n = 1'b0; dstb_n = 1'b1; hiw_n = 1'b0; low_n = 1'b0;
        addr = 24'h000000; wdata_in = 32'h5A5A_A5A5; ack_mute = 2'b00;
        repeat (3) @(negedge clk);
        #5 chk(ack_oe == 1'b0, "R2 no ack without strobe", {31'd0, ack_oe}, 32'd0);
        @(posedge clk); #1; dstb_n = 1'b0;
        @(negedge clk); #5;
        m[0] = 32'h5A5A_A5A5;
        chk(ack_oe == 1'b1 && ack_n == 1'b0, "R2 ack after strobe", {30'd0, ack_oe, ack_n}, 32'd2);
        @(posedge clk); #1; idle_bus();
        repeat (2) @(negedge clk);
        // R2 select with no word select
        @(posedge clk); #1;
        sel_n = 1'b0; wr_n = 1'b1;
        repeat (3) @(negedge clk);
        #5 chk(ack_oe == 1'b0, "R2 no ack without word select", {31'd0, ack_oe}, 32'd0);
        @(posedge clk); #1; idle_bus();
        repeat (2) @(negedge clk);
        xfer(1, 24'h000000, 0, 1, 1, 2'b00, 0);

        // random mix
        for (int n = 0; n < 400; n++) begin
            logic [31:0] r;
            bit hi, lo;
            r  = $urandom;
            hi = r[0]; lo = r[1];
            if (!hi && !lo) hi = 1'b1;
            xfer(r[2], 24'($urandom), $urandom, hi, lo, r[4:3], r[5]);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule